// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block chooses the handshake reply for one control endpoint of a full-speed USB device. The packet layer hands it a decoded token, and for OUT and SETUP it also passes the end of the data packet with the byte count, the data PID and an error flag. The block looks up the reply in a table indexed by the endpoint mode and the token. It sends that reply as a one-cycle strobe and waits for the packet layer to signal that the transaction has finished. Along the way it updates the stored byte count, data toggle, data-valid bit and the received-token flags, and it pulses an interrupt.

Firmware reaches two byte-wide registers through a simple read/write port. One holds the endpoint mode and the token flags. The other holds the byte count, the toggle and the data-valid bit. After any transaction that ends with an ACK, both registers refuse CPU writes. A CPU read made while no transaction is in progress lifts that lock, so firmware always sees what the hardware changed before it can overwrite it.

The sequencer has four states:
- IDLE: waits for a token.
- DATA: waits for the end of the data packet.
- REPLY: drives the handshake strobe for one cycle.
- WAIT: waits for the transaction-done strobe.

It moves between them as follows:
- Token accept: IDLE to DATA on OUT or SETUP.
- Immediate reply: IDLE to REPLY on an IN that gets an answer.
- Token drop: IDLE stays in IDLE on an IN that gets no answer.
- Data judged: DATA to REPLY when there is a handshake, or DATA to IDLE when the packet is dropped.
- Strobe out: REPLY to WAIT.
- Close: WAIT to IDLE on transaction done.

Top module: `usb_ep_handshake`

## Requirements
- R1: Mode codes are 0000 Disabled, 0001 NAK, 0010 Ignore, 0011 STALL and 1011 Control Write; every other code behaves as Disabled. An IN token is answered NAK in NAK or Control Write mode, STALL in STALL mode, and gets no handshake otherwise. Handshake codes are 0 none, 1 ACK, 2 NAK, 3 STALL.
- R2: When the OUT data packet is valid, OUT is answered ACK in Control Write mode, NAK in NAK mode, STALL in STALL mode, and gets no handshake in any other mode.
- R3: A data packet is valid only if it has no error and its byte count is at most EP_SIZE+2 (10 by default). An invalid packet never gets a handshake.
- R4: A valid SETUP is ACKed in every mode. When its transaction completes, the mode field is forced to 0001 (NAK).
- R5: An ACKed data packet loads the byte count and the toggle (from the DATA1 indication) and sets data-valid to 1. NAK, STALL, ignored and invalid transactions leave count, toggle and data-valid unchanged, except as stated in R6.
- R6: An error on a packet the endpoint would accept (SETUP, or OUT in Control Write mode) is FIFO corruption. It gives no handshake and a one-cycle irq in the cycle after the data end. The count is loaded and data-valid is cleared.
- R7: Every transaction that received a handshake pulses irq for one cycle, in the cycle after transaction done. Ignored transactions raise no irq.
- R8: The SETUP flag (mode register bit 7) sets in the cycle after a SETUP token. The IN flag (bit 6) and OUT flag (bit 5) set when a handshaken IN or OUT transaction completes. A hardware flag set wins over a CPU write in the same cycle.
- R9: Transaction done with an ACK handshake locks both registers against CPU writes. A CPU write in that same done cycle is dropped.
- R10: A CPU read of either register clears the lock only while the sequencer is idle. A read during a transaction, including in its done cycle, leaves the lock set.
- R11: hs_valid is high for exactly one cycle. For IN it is the cycle after the token; for OUT and SETUP it is the cycle after the data end. hs_code is 0 whenever hs_valid is low.
- R12: Register layout and reset:
  - Select 0 reads {SETUP flag, IN flag, OUT flag, 0, mode[3:0]}.
  - Select 1 reads {toggle, data-valid, 0, count[4:0]}.
  - A CPU write loads the same bit positions.
  - Reset clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Decoded token strobe |
| tok_kind | input | 2 | Token: 0 OUT, 1 IN, 2 SETUP |
| data_end | input | 1 | End of received data packet |
| rx_count | input | CNT_W | Received byte count including CRC |
| rx_pid1 | input | 1 | Data packet was DATA1 |
| rx_err | input | 1 | CRC or other packet error |
| txn_done | input | 1 | Transaction finished strobe |
| cpu_wr | input | 1 | CPU register write |
| cpu_rd | input | 1 | CPU register read |
| cpu_sel | input | 1 | Register select: 0 mode, 1 count |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected register contents |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK, 3 STALL |
| irq | output | 1 | Interrupt pulse |

## Verification
Two functions can land in the same cycle: the done strobe that sets the lock, and a CPU access to the registers. The bench provokes this by asserting a mode write, or a register read, together with txn_done at the close of an ACKed OUT. It then judges the result through later register reads. A write made in the done cycle must be absent from the readback, and a read made in the done cycle must leave the lock set, so a later idle-time write is still refused. Random traffic mixes writes, reads and transactions so that locked and unlocked writes meet every mode.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2
    } token_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_REPLY,
        ST_WAIT
    } state_e;

    localparam logic [3:0] MD_DISABLED = 4'b0000;
    localparam logic [3:0] MD_NAK      = 4'b0001;
    localparam logic [3:0] MD_IGNORE   = 4'b0010;
    localparam logic [3:0] MD_STALL    = 4'b0011;
    localparam logic [3:0] MD_CTRL_WR  = 4'b1011;

    localparam int REG_W = 8;
endpackage

// File: rtl/ep_hs_decide.sv
// Reply table: mode x token -> handshake, plus whether data would be stored.
module ep_hs_decide
    import ep_hs_pkg::*;
(
    input  logic [3:0] mode,
    input  logic [1:0] kind,
    output hs_e        resp,
    output logic       accepting
);
    always_comb begin
        resp      = HS_NONE;
        accepting = 1'b0;
        case (kind)
            TK_SETUP: begin
                resp      = HS_ACK;
                accepting = 1'b1;
            end
            TK_OUT: begin
                case (mode)
                    MD_CTRL_WR: begin
                        resp      = HS_ACK;
                        accepting = 1'b1;
                    end
                    MD_NAK:   resp = HS_NAK;
                    MD_STALL: resp = HS_STALL;
                    default:  resp = HS_NONE;
                endcase
            end
            TK_IN: begin
                case (mode)
                    MD_NAK, MD_CTRL_WR: resp = HS_NAK;
                    MD_STALL:           resp = HS_STALL;
                    default:            resp = HS_NONE;
                endcase
            end
            default: resp = HS_NONE;
        endcase
    end
endmodule

// File: rtl/ep_hs_fsm.sv
// Transaction sequencer: IDLE -> DATA -> REPLY -> WAIT -> IDLE.
module ep_hs_fsm
    import ep_hs_pkg::*;
#(
    parameter int EP_SIZE = 8,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             data_end,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_err,
    input  logic             txn_done,
    input  logic [3:0]       mode,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             irq,
    output logic             idle,
    output logic             ev_setup,
    output logic             ev_accept,
    output logic             ev_corrupt,
    output logic             ev_done,
    output logic [1:0]       done_kind,
    output hs_e              done_resp
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EP_SIZE + 2);

    state_e     state_q, state_d;
    logic [1:0] kind_q, kind_d;
    hs_e        resp_q, resp_d;
    logic       irq_q;
    logic [1:0] look_kind;
    hs_e        look_resp;
    logic       look_acc;
    logic       pkt_ok;

    assign look_kind = (state_q == ST_IDLE) ? tok_kind : kind_q;
    assign pkt_ok    = !rx_err && (rx_count <= LIMIT);

    ep_hs_decide u_decide (
        .mode      (mode),
        .kind      (look_kind),
        .resp      (look_resp),
        .accepting (look_acc)
    );

    // next-state
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        resp_d  = resp_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_valid) begin
                    kind_d = tok_kind;
                    if (tok_kind == TK_IN) begin
                        if (look_resp != HS_NONE) begin
                            resp_d  = look_resp;
                            state_d = ST_REPLY;
                        end
                    end else if (tok_kind == TK_OUT || tok_kind == TK_SETUP) begin
                        state_d = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (data_end) begin
                    if (pkt_ok && look_resp != HS_NONE) begin
                        resp_d  = look_resp;
                        state_d = ST_REPLY;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_REPLY: state_d = ST_WAIT;
            ST_WAIT:  if (txn_done) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= 2'd0;
            resp_q  <= HS_NONE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            resp_q  <= resp_d;
            irq_q   <= ev_done || ev_corrupt;
        end
    end

    // outputs
    always_comb begin
        idle       = (state_q == ST_IDLE);
        hs_valid   = (state_q == ST_REPLY);
        hs_code    = hs_valid ? resp_q : HS_NONE;
        irq        = irq_q;
        ev_setup   = idle && tok_valid && (tok_kind == TK_SETUP);
        ev_accept  = (state_q == ST_DATA) && data_end && pkt_ok && look_acc;
        ev_corrupt = (state_q == ST_DATA) && data_end && rx_err && look_acc;
        ev_done    = (state_q == ST_WAIT) && txn_done;
        done_kind  = kind_q;
        done_resp  = resp_q;
    end
endmodule

// File: rtl/ep_hs_regs.sv
// Mode/count registers with ACK-triggered write lock.
module ep_hs_regs
    import ep_hs_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic             cpu_sel,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             idle,
    input  logic             ev_setup,
    input  logic             ev_accept,
    input  logic             ev_corrupt,
    input  logic             ev_done,
    input  logic [1:0]       done_kind,
    input  hs_e              done_resp,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_pid1,
    output logic [3:0]       mode,
    output logic             locked
);
    logic [3:0]       mode_q;
    logic             setup_f, in_f, out_f;
    logic [CNT_W-1:0] count_q;
    logic             tog_q, dval_q, lock_q;
    logic             done_ack, wr_ok, wr_mode, wr_cnt;

    assign done_ack = ev_done && (done_resp == HS_ACK);
    assign wr_ok    = cpu_wr && !lock_q && !done_ack;
    assign wr_mode  = wr_ok && !cpu_sel;
    assign wr_cnt   = wr_ok && cpu_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MD_DISABLED;
            setup_f <= 1'b0;
            in_f    <= 1'b0;
            out_f   <= 1'b0;
            count_q <= '0;
            tog_q   <= 1'b0;
            dval_q  <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            if (done_ack && done_kind == TK_SETUP) mode_q <= MD_NAK;
            else if (wr_mode)                      mode_q <= cpu_wdata[3:0];

            if (ev_setup)     setup_f <= 1'b1;
            else if (wr_mode) setup_f <= cpu_wdata[7];

            if (ev_done && done_kind == TK_IN) in_f <= 1'b1;
            else if (wr_mode)                  in_f <= cpu_wdata[6];

            if (ev_done && done_kind == TK_OUT) out_f <= 1'b1;
            else if (wr_mode)                   out_f <= cpu_wdata[5];

            if (ev_accept) begin
                count_q <= rx_count;
                tog_q   <= rx_pid1;
                dval_q  <= 1'b1;
            end else if (ev_corrupt) begin
                count_q <= rx_count;
                dval_q  <= 1'b0;
            end else if (wr_cnt) begin
                count_q <= cpu_wdata[CNT_W-1:0];
                tog_q   <= cpu_wdata[7];
                dval_q  <= cpu_wdata[6];
            end

            if (done_ack)           lock_q <= 1'b1;
            else if (cpu_rd && idle) lock_q <= 1'b0;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_sel) begin
            cpu_rdata[CNT_W-1:0] = count_q;
            cpu_rdata[7]         = tog_q;
            cpu_rdata[6]         = dval_q;
        end else begin
            cpu_rdata[3:0] = mode_q;
            cpu_rdata[5]   = out_f;
            cpu_rdata[6]   = in_f;
            cpu_rdata[7]   = setup_f;
        end
    end

    assign mode   = mode_q;
    assign locked = lock_q;
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
    import ep_hs_pkg::*;
#(
    parameter int EP_SIZE = 8,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             data_end,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_pid1,
    input  logic             rx_err,
    input  logic             txn_done,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic             cpu_sel,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             irq
);
    logic       st_idle, ev_setup, ev_accept, ev_corrupt, ev_done, wr_lock;
    logic [1:0] done_kind;
    hs_e        done_resp;
    logic [3:0] mode_q;

    ep_hs_fsm #(.EP_SIZE(EP_SIZE), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid),
        .tok_kind   (tok_kind),
        .data_end   (data_end),
        .rx_count   (rx_count),
        .rx_err     (rx_err),
        .txn_done   (txn_done),
        .mode       (mode_q),
        .hs_valid   (hs_valid),
        .hs_code    (hs_code),
        .irq        (irq),
        .idle       (st_idle),
        .ev_setup   (ev_setup),
        .ev_accept  (ev_accept),
        .ev_corrupt (ev_corrupt),
        .ev_done    (ev_done),
        .done_kind  (done_kind),
        .done_resp  (done_resp)
    );

    ep_hs_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_sel    (cpu_sel),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .idle       (st_idle),
        .ev_setup   (ev_setup),
        .ev_accept  (ev_accept),
        .ev_corrupt (ev_corrupt),
        .ev_done    (ev_done),
        .done_kind  (done_kind),
        .done_resp  (done_resp),
        .rx_count   (rx_count),
        .rx_pid1    (rx_pid1),
        .mode       (mode_q),
        .locked     (wr_lock)
    );
endmodule

// File: rtl/ep_hs_checker.sv
module ep_hs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       irq,
    input logic       tok_valid,
    input logic [1:0] tok_kind,
    input logic       txn_done,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic       idle,
    input logic       lock_q,
    input logic [3:0] mode_q
);
    a_r11_hs_single: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);

    a_r11_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_valid |-> hs_code == 2'd0);

    a_r11_code_real: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> hs_code != 2'd0);

    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r9_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(txn_done));

    a_r10_unlock_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(cpu_rd && idle));

    a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && cpu_wr && idle) |=> $stable(mode_q));

    a_r1_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && tok_valid && tok_kind == 2'd1 && mode_q == 4'b0011)
        |=> (hs_valid && hs_code == 2'd3));
endmodule

bind usb_ep_handshake ep_hs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code),
    .irq       (irq),
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .txn_done  (txn_done),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .idle      (st_idle),
    .lock_q    (wr_lock),
    .mode_q    (mode_q)
);

// File: tb/sim_usb_ep_handshake.sv
`timescale 1ns/1ps
module sim_usb_ep_handshake;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic       data_end = 1'b0;
    logic [4:0] rx_count = 5'd0;
    logic       rx_pid1 = 1'b0;
    logic       rx_err = 1'b0;
    logic       txn_done = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic       cpu_sel = 1'b0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    // bench model of the register contents
    logic [3:0] m_mode;
    logic       m_sf, m_if, m_of, m_tog, m_dval, m_lock;
    logic [4:0] m_cnt;

    always #5 clk = ~clk;

    usb_ep_handshake u0 (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .data_end(data_end), .rx_count(rx_count), .rx_pid1(rx_pid1),
        .rx_err(rx_err), .txn_done(txn_done), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .hs_valid(hs_valid), .hs_code(hs_code), .irq(irq)
    );

    function automatic logic [1:0] f_resp(input logic [3:0] md, input logic [1:0] k);
        if (k == 2'd2) return 2'd1;
        if (k == 2'd0) begin
            if (md == 4'b1011) return 2'd1;
            if (md == 4'b0001) return 2'd2;
            if (md == 4'b0011) return 2'd3;
            return 2'd0;
        end
        if (k == 2'd1) begin
            if (md == 4'b0001 || md == 4'b1011) return 2'd2;
            if (md == 4'b0011) return 2'd3;
        end
        return 2'd0;
    endfunction

    function automatic logic f_accept(input logic [3:0] md, input logic [1:0] k);
        return (k == 2'd2) || (k == 2'd0 && md == 4'b1011);
    endfunction

    function automatic logic [7:0] f_mode_reg();
        return {m_sf, m_if, m_of, 1'b0, m_mode};
    endfunction

    function automatic logic [7:0] f_cnt_reg();
        return {m_tog, m_dval, 1'b0, m_cnt};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic sel, input logic [7:0] d);
        if (!sel) begin
            m_mode = d[3:0]; m_sf = d[7]; m_if = d[6]; m_of = d[5];
        end else begin
            m_cnt = d[4:0]; m_tog = d[7]; m_dval = d[6];
        end
    endtask

    task automatic cpu_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (!m_lock) model_write(sel, d);
    endtask

    // R12 layout, R10 unlock by idle read
    task automatic cpu_read_check(input logic sel, input string req);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_sel = sel;
        #1;
        chk(req, cpu_rdata, sel ? f_cnt_reg() : f_mode_reg());
        @(negedge clk);
        cpu_rd = 1'b0;
        m_lock = 1'b0;
    endtask

    // mode: 0 none, 1 write at done, 2 read at done
    task automatic close_txn(input logic [1:0] k, input logic [1:0] r,
                             input int coll, input logic [7:0] cd);
        logic lock_before;
        @(negedge clk);
        chk("R11 strobe one cycle", hs_valid, 1'b0);
        lock_before = m_lock;
        txn_done = 1'b1;
        if (coll == 1) begin cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_wdata = cd; end
        if (coll == 2) begin cpu_rd = 1'b1; cpu_sel = 1'b0; end
        @(negedge clk);
        txn_done = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
        if (coll == 1 && !lock_before && r != 2'd1) model_write(1'b0, cd);
        if (r == 2'd1) m_lock = 1'b1;
        if (r == 2'd1 && k == 2'd2) m_mode = 4'b0001;
        if (k == 2'd1) m_if = 1'b1;
        if (k == 2'd0) m_of = 1'b1;
        chk("R7 irq after done", irq, 1'b1);
    endtask

    task automatic run_txn(input logic [1:0] k, input logic [4:0] cnt, input logic err,
                           input logic pid, input int coll, input logic [7:0] cd);
        logic [1:0] r;
        logic ok, acc, corrupt;
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = k;
        r   = f_resp(m_mode, k);
        acc = f_accept(m_mode, k);
        @(negedge clk);
        tok_valid = 1'b0;
        if (k == 2'd2) m_sf = 1'b1;
        if (k == 2'd1) begin
            chk("R1 IN handshake", {hs_valid, hs_code}, {r != 2'd0, r});
            if (r == 2'd0) chk("R7 no irq on ignored IN", irq, 1'b0);
            else close_txn(k, r, coll, cd);
        end else begin
            data_end = 1'b1; rx_count = cnt; rx_err = err; rx_pid1 = pid;
            @(negedge clk);
            data_end = 1'b0;
            ok      = !err && (cnt <= 5'd10);
            corrupt = err && acc;
            if (!ok) r = 2'd0;
            if (ok && acc) begin m_cnt = cnt; m_tog = pid; m_dval = 1'b1; end
            else if (corrupt) begin m_cnt = cnt; m_dval = 1'b0; end
            chk(k == 2'd2 ? "R4 SETUP handshake" : "R2 R3 OUT handshake",
                {hs_valid, hs_code}, {r != 2'd0, r});
            chk("R6 corrupt irq", irq, corrupt);
            if (r != 2'd0) close_txn(k, r, coll, cd);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [3:0] modes [6];
        void'($urandom(32'd20240611));
        modes[0] = 4'b0000; modes[1] = 4'b0001; modes[2] = 4'b0010;
        modes[3] = 4'b0011; modes[4] = 4'b1011; modes[5] = 4'b0110;
        m_mode = 4'd0; m_sf = 0; m_if = 0; m_of = 0; m_tog = 0; m_dval = 0;
        m_lock = 0; m_cnt = 5'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset no handshake", hs_valid, 1'b0);
        chk("R7 reset irq low", irq, 1'b0);
        cpu_read_check(1'b0, "R12 reset mode reg");
        cpu_read_check(1'b1, "R12 reset count reg");

        // R2 R3 boundary: count 10 ACKed in Control Write
        cpu_write(1'b0, 8'h0B);
        run_txn(2'd0, 5'd10, 1'b0, 1'b1, 0, 8'h00);
        // R9: write while locked is dropped
        cpu_write(1'b0, 8'h03);
        cpu_read_check(1'b0, "R9 locked write dropped");
        cpu_read_check(1'b1, "R5 count toggle dval after ACK");
        // R10: read unlocked, write now lands
        cpu_write(1'b0, 8'h0B);
        cpu_read_check(1'b0, "R10 write after unlock");
        // R3: count 11 ignored, R5 regs unchanged
        run_txn(2'd0, 5'd11, 1'b0, 1'b0, 0, 8'h00);
        cpu_read_check(1'b1, "R5 oversize leaves count");
        // R6: CRC error on accepting endpoint
        run_txn(2'd0, 5'd6, 1'b1, 1'b0, 0, 8'h00);
        cpu_read_check(1'b1, "R6 corrupt clears dval");
        // R1 R2 STALL mode
        cpu_write(1'b0, 8'h03);
        run_txn(2'd1, 5'd0, 1'b0, 1'b0, 0, 8'h00);
        run_txn(2'd0, 5'd4, 1'b0, 1'b1, 0, 8'h00);
        cpu_read_check(1'b1, "R5 STALL leaves count");
        cpu_read_check(1'b0, "R8 IN OUT flags");
        // R1 Ignore mode
        cpu_write(1'b0, 8'h02);
        run_txn(2'd1, 5'd0, 1'b0, 1'b0, 0, 8'h00);
        // R4 SETUP in Disabled, mode forced to NAK
        cpu_write(1'b0, 8'h00);
        run_txn(2'd2, 5'd10, 1'b0, 1'b0, 0, 8'h00);
        cpu_read_check(1'b0, "R4 mode forced NAK and R8 setup flag");
        // R9 write colliding with ACK done is dropped
        cpu_write(1'b0, 8'h0B);
        run_txn(2'd0, 5'd3, 1'b0, 1'b0, 1, 8'h03);
        cpu_read_check(1'b0, "R9 same-cycle write dropped");
        // R10 read colliding with done keeps lock
        run_txn(2'd0, 5'd5, 1'b0, 1'b1, 2, 8'h00);
        cpu_write(1'b0, 8'h01);
        cpu_read_check(1'b0, "R10 done-cycle read keeps lock");

        // constrained random traffic
        for (int i = 0; i < 400; i++) begin
            int pick;
            pick = $urandom_range(0, 99);
            if (pick < 20) begin
                logic [7:0] d;
                d = $urandom_range(0, 255);
                if ($urandom_range(0, 1) == 0) cpu_write(1'b1, d);
                else cpu_write(1'b0, {d[7:5], 1'b0, modes[$urandom_range(0, 5)]});
            end else if (pick < 35) begin
                cpu_read_check($urandom_range(0, 1) == 1, "R12 random readback");
            end else begin
                logic [1:0] k;
                logic [4:0] c;
                k = 2'($urandom_range(0, 2));
                c = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(11, 31))
                                                : 5'($urandom_range(0, 10));
                run_txn(k, c, $urandom_range(0, 5) == 0, $urandom_range(0, 1) == 1,
                        0, 8'h00);
            end
        end
        cpu_read_check(1'b0, "R8 final mode reg");
        cpu_read_check(1'b1, "R5 final count reg");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule